// File: doc/BRIEF.md
# CCD Electronic Shutter Sweep Pulse Generator

This block drives the substrate charge-sweep pulse that sets how long a CCD sensor gathers charge. It follows the line strobe and the field strobe from the sync generator, watches the start of each readout pulse, and reads a 9-bit load value and a two-bit mode code. In the fast mode it sweeps charge once per line from the start of the field. It stops sweeping once the line index reaches `0x1FF - load`, so exposure shortens as the load value falls. In the slow mode it never sweeps. Instead it lets readout through on only one field out of every `2 * (0x1FF - load)`, so charge builds up across many fields.

An active-low trigger input allows continuously variable exposure. A falling trigger edge stops the sweeps until the next readout starts, so exposure runs from that trigger edge to the readout. A flicker-free mode uses a fixed load chosen by the line system. The output stage has a single gate: a low enable or the off mode keeps the pulse low. All pins are plain control levels or single-cycle strobes. Nothing carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `shutter_sweep_gen`

## Requirements
- R1: After reset `sweep` is low and `rdo_allow` is high.
- R2: In fast mode (mode code 2'b01) the line index is cleared to 0 by `vd`. An `hd` in the same cycle as `vd` starts line 0, and each later `hd` adds one, saturating at 1023. A line gets a sweep pulse when its index is below `0x1FF - load`.
- R3: A sweep pulse rises `SWEEP_OFS + 1` cycles after the clock edge that samples its `hd`, and stays high for `SWEEP_W` cycles.
- R4: In flicker-free mode (2'b00) the line limit is `0x1FF - 0x196` = 105 when `sys625` is low. It is 0 (no sweeps) when `sys625` is high.
- R5: In slow mode (2'b10) `sweep` stays low. `rdo_allow` is high during one field in every `2 * (0x1FF - load)`: the field whose count, advanced by each `vd`, has reached `2 * (0x1FF - load) - 1`. The count then wraps to 0 on the next `vd`. In every other mode `rdo_allow` is high.
- R6: In slow mode a load of `0x1FF` is outside the legal range; `rdo_allow` then stays high.
- R7: A falling edge on `trig_n` blocks sweep pulses from the next cycle on. The block holds until the next rising edge of `rdo`. When both edges land in the same cycle, the trigger edge wins.
- R8: While `trig_n` stays high, the programmed sweep pattern is unchanged.
- R9: Low `enable`, or off mode (2'b11), forces `sweep` low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hd | input | 1 | Line start strobe, one cycle |
| vd | input | 1 | Field start strobe, one cycle |
| rdo | input | 1 | Readout pulse, active high |
| trig_n | input | 1 | Exposure trigger, falling edge stops sweeping |
| enable | input | 1 | Shutter enable |
| mode | input | 2 | 00 flicker-free, 01 fast, 10 slow, 11 off |
| sys625 | input | 1 | High selects the 625-line system |
| load | input | 9 | Shutter load value |
| sweep | output | 1 | Charge-sweep pulse |
| rdo_allow | output | 1 | High on fields where readout may occur |

## Verification
The bench builds the block with `SWEEP_OFS = 3` and `SWEEP_W = 2`, so that a whole pulse fits in a 16-cycle line. With 24-line fields, loads near `0x1FF` put the line limit inside the field, at the field edge, or past it. The flicker-free limit of 105 lines therefore shows up as sweeping on every line. A load of `0x1FD` gives a four-field slow span, so several wraps of the field count fit in a short run. Trigger edges placed mid-field, paired with readout pulses early in each field, reach both the hold and the release of R7.

// File: rtl/shr_pkg.sv
package shr_pkg;
  typedef enum logic [1:0] {
    SHR_FLICK = 2'b00,
    SHR_FAST  = 2'b01,
    SHR_SLOW  = 2'b10,
    SHR_OFF   = 2'b11
  } shr_mode_e;
endpackage

// File: rtl/shr_line_track.sv
module shr_line_track #(
  parameter int LINE_W    = 10,
  parameter int SWEEP_OFS = 12,
  parameter int SWEEP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hd,
  input  logic              vd,
  input  logic [LINE_W-1:0] stop_line,
  output logic              win
);
  localparam int POS_MAX = SWEEP_OFS + SWEEP_W;
  localparam int POS_W   = $clog2(POS_MAX + 1);
  localparam logic [POS_W-1:0]  OFS_V  = POS_W'(SWEEP_OFS);
  localparam logic [POS_W-1:0]  MAX_V  = POS_W'(POS_MAX);
  localparam logic [LINE_W-1:0] LINE_TOP = {LINE_W{1'b1}};

  logic [LINE_W-1:0] line_q, line_nxt;
  logic [POS_W-1:0]  pos_q;
  logic              armed_q;

  always_comb begin
    line_nxt = line_q;
    if (vd)
      line_nxt = '0;
    else if (hd && line_q != LINE_TOP)
      line_nxt = line_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= '0;
      pos_q   <= MAX_V;
      armed_q <= 1'b0;
    end else begin
      line_q <= line_nxt;
      if (hd) begin
        pos_q   <= '0;
        armed_q <= (line_nxt < stop_line);
      end else if (pos_q < MAX_V) begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign win = armed_q && (pos_q >= OFS_V) && (pos_q < MAX_V);

  // R2
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hd && !vd && line_q != LINE_TOP) |=> (line_q == $past(line_q) + 1'b1));

  // R2
  line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vd |=> (line_q == '0));
endmodule

// File: rtl/shr_field_track.sv
module shr_field_track #(
  parameter int LOAD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vd,
  input  logic              slow_mode,
  input  logic [LOAD_W-1:0] load,
  output logic              rdo_allow
);
  localparam int FIELD_W = LOAD_W + 1;
  localparam logic [LOAD_W-1:0] LOAD_TOP = {LOAD_W{1'b1}};

  logic [FIELD_W-1:0] span, span_m1, fcnt_q;

  assign span    = {LOAD_TOP - load, 1'b0};
  assign span_m1 = span - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)
      fcnt_q <= '0;
    else if (vd) begin
      if (span == '0 || fcnt_q >= span_m1)
        fcnt_q <= '0;
      else
        fcnt_q <= fcnt_q + 1'b1;
    end
  end

  assign rdo_allow = !slow_mode || (span == '0) || (fcnt_q >= span_m1);

  // R5
  allow_on_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rdo_allow) && slow_mode && $past(slow_mode) && $stable(load)) |-> $past(vd));

  // R6
  bad_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load == LOAD_TOP) |-> rdo_allow);
endmodule

// File: rtl/shr_trig_gate.sv
module shr_trig_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_n,
  input  logic rdo,
  output logic hold
);
  logic trig_prev_q, rdo_prev_q, hold_q;
  logic trig_fall, rdo_rise;

  assign trig_fall = trig_prev_q && !trig_n;
  assign rdo_rise  = rdo && !rdo_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_prev_q <= 1'b1;
      rdo_prev_q  <= 1'b0;
      hold_q      <= 1'b0;
    end else begin
      trig_prev_q <= trig_n;
      rdo_prev_q  <= rdo;
      if (trig_fall)
        hold_q <= 1'b1;
      else if (rdo_rise)
        hold_q <= 1'b0;
    end
  end

  assign hold = hold_q;

  // R7
  trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_prev_q && !trig_n) |=> hold);

  // R7
  rdo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdo && !rdo_prev_q && !(trig_prev_q && !trig_n)) |=> !hold);
endmodule

// File: rtl/shutter_sweep_gen.sv
module shutter_sweep_gen #(
  parameter int LOAD_W       = 9,
  parameter int SWEEP_OFS    = 12,
  parameter int SWEEP_W      = 4,
  parameter int FLK_LOAD_525 = 'h196,
  parameter int FLK_LOAD_625 = 'h1FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hd,
  input  logic              vd,
  input  logic              rdo,
  input  logic              trig_n,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic              sys625,
  input  logic [LOAD_W-1:0] load,
  output logic              sweep,
  output logic              rdo_allow
);
  import shr_pkg::*;

  localparam int LINE_W = LOAD_W + 1;
  localparam logic [LOAD_W-1:0] LOAD_TOP = {LOAD_W{1'b1}};
  localparam logic [LOAD_W-1:0] FLK_A = LOAD_W'(FLK_LOAD_525);
  localparam logic [LOAD_W-1:0] FLK_B = LOAD_W'(FLK_LOAD_625);

  shr_mode_e         mode_e;
  logic [LOAD_W-1:0] eff_load;
  logic [LINE_W-1:0] stop_line;
  logic              win, hold, pass, sweep_q;

  assign mode_e = shr_mode_e'(mode);

  always_comb begin
    case (mode_e)
      SHR_FLICK: eff_load = sys625 ? FLK_B : FLK_A;
      SHR_FAST:  eff_load = load;
      default:   eff_load = LOAD_TOP;
    endcase
  end

  assign stop_line = {1'b0, LOAD_TOP - eff_load};

  shr_line_track #(
    .LINE_W   (LINE_W),
    .SWEEP_OFS(SWEEP_OFS),
    .SWEEP_W  (SWEEP_W)
  ) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .hd       (hd),
    .vd       (vd),
    .stop_line(stop_line),
    .win      (win)
  );

  shr_field_track #(
    .LOAD_W(LOAD_W)
  ) u_field (
    .clk      (clk),
    .rst_n    (rst_n),
    .vd       (vd),
    .slow_mode(mode_e == SHR_SLOW),
    .load     (load),
    .rdo_allow(rdo_allow)
  );

  shr_trig_gate u_trig (
    .clk   (clk),
    .rst_n (rst_n),
    .trig_n(trig_n),
    .rdo   (rdo),
    .hold  (hold)
  );

  assign pass = enable && (mode_e == SHR_FAST || mode_e == SHR_FLICK);

  always_ff @(posedge clk) begin
    if (!rst_n)
      sweep_q <= 1'b0;
    else
      sweep_q <= win && pass && !hold;
  end

  assign sweep = sweep_q;

  // R9
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || mode == 2'b11) |=> !sweep);

  // R5
  slow_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |=> !sweep);

  // R7
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !sweep);

  // R5
  allow_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b10) |-> rdo_allow);
endmodule

// File: tb/shutter_sweep_gen_tb.sv
module shutter_sweep_gen_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int OFS = 3, WID = 2, LLEN = 16, NLINES = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hd = 0, vd = 0, rdo = 0, trig_n = 1, enable = 1, sys625 = 0;
  logic [1:0] mode = 2'b01;
  logic [8:0] load = 9'h1FF;
  logic sweep, rdo_allow;

  always #2.5 clk = ~clk;

  shutter_sweep_gen #(.SWEEP_OFS(OFS), .SWEEP_W(WID)) u_dut (
    .clk(clk), .rst_n(rst_n), .hd(hd), .vd(vd), .rdo(rdo), .trig_n(trig_n),
    .enable(enable), .mode(mode), .sys625(sys625), .load(load),
    .sweep(sweep), .rdo_allow(rdo_allow));

  int errors = 0, checks = 0, cycles = 0;
  string tag = "R1";
  bit chk_on = 0;

  // reference model state
  int m_line = 0, m_pos = OFS + WID, m_fcnt = 0;
  bit m_armed = 0, m_hold = 0, m_tprev = 1, m_rprev = 0, m_sweep = 0;

  function automatic int limit_of();
    case (mode)
      2'b00: return sys625 ? 0 : (511 - 'h196);
      2'b01: return 511 - int'(load);
      default: return 0;
    endcase
  endfunction

  function automatic int span_of();
    return 2 * (511 - int'(load));
  endfunction

  always @(posedge clk) begin
    bit nxt_sweep;
    int nl;
    if (!rst_n) begin
      m_line = 0; m_pos = OFS + WID; m_fcnt = 0; m_armed = 0;
      m_hold = 0; m_tprev = 1; m_rprev = 0; m_sweep = 0;
    end else begin
      nxt_sweep = m_armed && m_pos >= OFS && m_pos < OFS + WID && enable &&
                  (mode == 2'b00 || mode == 2'b01) && !m_hold;
      if (m_tprev && !trig_n) m_hold = 1;
      else if (rdo && !m_rprev) m_hold = 0;
      m_tprev = trig_n; m_rprev = rdo;
      nl = vd ? 0 : (hd && m_line < 1023) ? m_line + 1 : m_line;
      if (hd) begin
        m_pos = 0;
        m_armed = nl < limit_of();
      end else if (m_pos < OFS + WID) m_pos++;
      m_line = nl;
      if (vd) begin
        if (span_of() == 0 || m_fcnt >= span_of() - 1) m_fcnt = 0;
        else m_fcnt++;
      end
      m_sweep = nxt_sweep;
    end
  end

  always @(posedge clk) begin
    bit exp_allow;
    #1;
    if (chk_on) begin
      exp_allow = (mode != 2'b10) || span_of() == 0 || m_fcnt >= span_of() - 1;
      checks += 2;
      if (sweep !== m_sweep) begin
        errors++;
        $display("FAIL %s sweep actual=%0b expected=%0b t=%0t", tag, sweep, m_sweep, $time);
      end
      if (rdo_allow !== exp_allow) begin
        errors++;
        $display("FAIL %s rdo_allow actual=%0b expected=%0b t=%0t", tag, rdo_allow, exp_allow, $time);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  int g_cyc = 0, g_line = 0;
  bit rdo_en = 0, trig_en = 0;

  task automatic step();
    @(negedge clk);
    hd = (g_cyc == 0);
    vd = (g_cyc == 0 && g_line == 0);
    rdo = rdo_en && g_line == 2 && g_cyc < 3;
    trig_n = !(trig_en && g_line >= 8 && g_line < 12);
    if (++g_cyc == LLEN) begin
      g_cyc = 0;
      if (++g_line == NLINES) g_line = 0;
    end
  endtask

  task automatic run_fields(input int n);
    for (int i = 0; i < n * NLINES * LLEN; i++) step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks += 2;
    if (sweep !== 1'b0) begin errors++; $display("FAIL R1 sweep actual=%0b expected=0", sweep); end
    if (rdo_allow !== 1'b1) begin errors++; $display("FAIL R1 rdo_allow actual=%0b expected=1", rdo_allow); end
    rst_n = 1; chk_on = 1;
    tag = "R2/R3 fast limit 10"; load = 9'h1FF - 9'd10; run_fields(2);
    tag = "R2 fast limit 0";     load = 9'h1FF;         run_fields(1);
    tag = "R2 fast limit 24";    load = 9'h1FF - 9'd24; run_fields(2);
    tag = "R4 flicker 525"; mode = 2'b00; sys625 = 0; run_fields(2);
    tag = "R4 flicker 625"; sys625 = 1; run_fields(1);
    sys625 = 0;
    tag = "R5 slow span 4"; mode = 2'b10; load = 9'h1FD; run_fields(9);
    tag = "R6 slow bad load"; load = 9'h1FF; run_fields(2);
    tag = "R8 trig high"; mode = 2'b01; load = 9'h1FF - 9'd20; rdo_en = 1; run_fields(2);
    tag = "R7 trig gate"; trig_en = 1; run_fields(3);
    tag = "R7 flicker trig"; mode = 2'b00; run_fields(2);
    trig_en = 0; rdo_en = 0;
    tag = "R7 release"; rdo_en = 1; run_fields(1); rdo_en = 0;
    tag = "R9 enable low"; mode = 2'b01; enable = 0; run_fields(1);
    tag = "R9 enable mid"; enable = 1; run_fields(1);
    for (int k = 0; k < 40; k++) begin enable = k[2]; step(); end
    enable = 1;
    tag = "R9 off mode"; mode = 2'b11; run_fields(1);
    for (int k = 0; k < 40; k++) begin mode = k[3] ? 2'b11 : 2'b01; step(); end
    mode = 2'b01; run_fields(1);
    chk_on = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule